// File: doc/BRIEF.md
# Posit Encoder from Fixed-Field Intermediate Word

This block is purely combinational. It takes a value held in a fixed-field floating-point intermediate word and packs it into an N-bit posit with exponent-field width ES. The intermediate word carries a NaR flag, a sign, a biased exponent, an explicit leading bit, a WF-bit fraction, a round bit and a sticky bit. An arithmetic unit (adder, multiplier, accumulator readout) produces that word, and this encoder is the last stage before the result is stored.

The significand is kept in two's complement. The value of a word is 2^(exp − BIAS) × (imp + frac/2^WF − 2·sign), where BIAS = (N−2)·2^ES + 1, WF = N−3−ES and the exponent field is WE = 1 + ES + ceil(log2(N−2)) bits wide. The round bit weighs half a fraction LSB, and the sticky bit flags any nonzero weight below the round bit. The regime length is known only once the exponent is known, so the rounding position moves with the magnitude. The encoder finds the bits that fall past the posit LSB after a variable shift and rounds to nearest with ties to even. Results outside the representable range saturate.

Top module: `posit_encoder`

## Requirements
- R1: When the NaR flag is set, the output is a 1 in bit N−1 with all other bits 0, whatever the other fields hold.
- R2: When the NaR flag is clear and both sign and leading bit are 0, the output is all zeros, whatever the exponent, fraction, round and sticky fields hold.
- R3: For a nonzero number the leading bit equals the inverse of the sign. Every word that exactly represents a posit value (round and sticky 0) encodes to that posit.
- R4: A value exactly halfway between two adjacent posits (round 1, sticky 0, with all lower kept bits exact) encodes to the neighbour whose bit 0 is 0.
- R5: A value that is not a tie encodes to the nearer neighbour: round 1 with sticky 1 goes to the next posit up in value, and round 0 with sticky 1 stays at the lower one.
- R6: When the regime is long, fraction bits that no longer fit in the posit still decide the rounding. For N=8, ES=0 the value 1.5·2^5 gives 0x7E (tie to even), and 1.75·2^5 gives 0x7F.
- R7: A magnitude at or above the largest posit, or one that would round past it, gives the largest positive pattern (0111…1) or its negation (100…01). It never gives the NaR code.
- R8: A nonzero magnitude below the smallest posit gives 00…01 or 11…11 according to the sign. It never gives zero.
- R9: A negative result is the two's complement of the encoding of its magnitude, and the output bit N−1 equals the input sign for every nonzero number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_nar | input | 1 | Not-a-real flag |
| in_sign | input | 1 | Sign of the two's complement significand |
| in_exp | input | WE | Biased exponent |
| in_imp | input | 1 | Explicit leading significand bit |
| in_frac | input | WF | Fraction bits |
| in_rnd | input | 1 | Bit of weight half a fraction LSB |
| in_stk | input | 1 | OR of all lower-weight bits |
| out_posit | output | N | Encoded posit |

## Verification
The bound checker checks the special codes on every input combination the bench applies. It confirms that a NaR flag always gives the NaR code and that a zero word always gives zero. It also confirms that a nonzero number never gives zero or NaR, that the output sign follows the input sign, and that the internal overflow and underflow clamps yield exactly the extreme patterns. Only the bench scenarios can show that the encoding is the right posit. The bench re-encodes every 8-bit and 16-bit posit after decoding it arithmetically, and it builds tie, above-half and below-half cases around full-precision posits. Directed cases cover rounding at long regimes and carries into the largest magnitude.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    PC_ZERO = 2'd0,
    PC_NAR  = 2'd1,
    PC_NUM  = 2'd2
  } pcls_e;
endpackage

// File: rtl/pe_magnitude.sv
// Turns the two's complement significand into a magnitude and removes the bias.
module pe_magnitude #(
  parameter int N  = 16,
  parameter int ES = 1,
  parameter int WF = N - 3 - ES,
  parameter int WE = 1 + ES + $clog2(N - 2),
  parameter int EW = WE + 2
) (
  input  logic                 sign,
  input  logic                 imp,
  input  logic [WE-1:0]        exp_b,
  input  logic [WF-1:0]        frac,
  input  logic                 rnd,
  input  logic                 stk,
  output logic signed [EW-1:0] sexp,
  output logic [WF-1:0]        mfrac,
  output logic                 mrnd
);
  localparam int MW = WF + 3;
  localparam int BIAS = ((N - 2) << ES) + 1;
  localparam logic signed [EW-1:0] BIAS_V = EW'(BIAS);

  logic [MW-1:0] tc_bits;
  logic [MW-1:0] neg_bits;
  logic [MW-1:0] mag_bits;
  logic          two;

  always_comb begin
    tc_bits  = {sign, imp, frac, rnd};
    // sticky set: the lower tail absorbs the +1 of the negation
    neg_bits = ~tc_bits + {{(MW-1){1'b0}}, ~stk};
    mag_bits = sign ? neg_bits : tc_bits;
    two      = mag_bits[MW-1];
    mfrac    = two ? '0 : mag_bits[WF:1];
    mrnd     = two ? 1'b0 : mag_bits[0];
    sexp     = $signed({2'b00, exp_b}) - BIAS_V + $signed({{(EW-1){1'b0}}, two});
  end
endmodule

// File: rtl/pe_regime.sv
// Builds the regime/exponent/fraction string by a variable arithmetic shift.
module pe_regime #(
  parameter int N  = 16,
  parameter int ES = 1,
  parameter int WF = N - 3 - ES,
  parameter int EW = 8
) (
  input  logic signed [EW-1:0] sexp,
  input  logic [WF-1:0]        mfrac,
  input  logic                 mrnd,
  input  logic                 stk,
  output logic [N-2:0]         body,
  output logic                 guard,
  output logic                 sticky,
  output logic                 sat_hi,
  output logic                 sat_lo
);
  localparam int XW = 2 * N - 3;
  localparam logic signed [EW-1:0] K_HI = EW'(N - 2);
  localparam logic signed [EW-1:0] K_LO = -EW'(N - 2);

  logic signed [EW-1:0] k;
  logic [EW-1:0]        amt;
  logic                 rb;
  logic [N-1:0]         seed;
  logic signed [XW-1:0] ext;
  logic signed [XW-1:0] sh;

  assign k  = sexp >>> ES;
  assign rb = ~k[EW-1];

  generate
    if (ES > 0) begin : g_es
      assign seed = {rb, ~rb, sexp[ES-1:0], mfrac, mrnd};
    end else begin : g_noes
      assign seed = {rb, ~rb, mfrac, mrnd};
    end
  endgenerate

  always_comb begin
    sat_hi = (k >= K_HI);
    sat_lo = (k < K_LO);
    amt    = k[EW-1] ? ~k : k;
    ext    = {seed, {(N-3){1'b0}}};
    sh     = ext >>> amt;
    body   = sh[XW-1 -: N-1];
    guard  = sh[N-3];
    sticky = (|sh[N-4:0]) | stk;
  end
endmodule

// File: rtl/pe_round.sv
// Round to nearest even, clamp, restore the sign and select special codes.
module pe_round #(
  parameter int N = 16
) (
  input  pe_pkg::pcls_e cls,
  input  logic          sign,
  input  logic [N-2:0]  body,
  input  logic          guard,
  input  logic          sticky,
  input  logic          sat_hi,
  input  logic          sat_lo,
  output logic [N-1:0]  posit
);
  logic         up;
  logic [N-2:0] mag;
  logic [N-1:0] full;

  always_comb begin
    up = guard & (sticky | body[0]);
    if (sat_hi)                mag = '1;
    else if (sat_lo)           mag = {{(N-2){1'b0}}, 1'b1};
    else if (up && !(&body))   mag = body + 1'b1;
    else                       mag = body;
    full = {1'b0, mag};
    unique case (cls)
      pe_pkg::PC_NAR:  posit = {1'b1, {(N-1){1'b0}}};
      pe_pkg::PC_ZERO: posit = '0;
      default:         posit = sign ? (~full + 1'b1) : full;
    endcase
  end
endmodule

// File: rtl/posit_encoder.sv
module posit_encoder #(
  parameter  int N  = 16,
  parameter  int ES = 1,
  localparam int WF = N - 3 - ES,
  localparam int WE = 1 + ES + $clog2(N - 2)
) (
  input  logic          in_nar,
  input  logic          in_sign,
  input  logic [WE-1:0] in_exp,
  input  logic          in_imp,
  input  logic [WF-1:0] in_frac,
  input  logic          in_rnd,
  input  logic          in_stk,
  output logic [N-1:0]  out_posit
);
  localparam int EW = WE + 2;

  pe_pkg::pcls_e        cls;
  logic signed [EW-1:0] sexp;
  logic [WF-1:0]        mfrac;
  logic                 mrnd;
  logic [N-2:0]         body;
  logic                 guard;
  logic                 sticky;
  logic                 sat_hi;
  logic                 sat_lo;

  always_comb begin
    if (in_nar)                  cls = pe_pkg::PC_NAR;
    else if (!in_sign && !in_imp) cls = pe_pkg::PC_ZERO;
    else                         cls = pe_pkg::PC_NUM;
  end

  pe_magnitude #(.N(N), .ES(ES), .WF(WF), .WE(WE), .EW(EW)) u_mag (
    .sign(in_sign), .imp(in_imp), .exp_b(in_exp), .frac(in_frac),
    .rnd(in_rnd), .stk(in_stk), .sexp(sexp), .mfrac(mfrac), .mrnd(mrnd)
  );

  pe_regime #(.N(N), .ES(ES), .WF(WF), .EW(EW)) u_reg (
    .sexp(sexp), .mfrac(mfrac), .mrnd(mrnd), .stk(in_stk),
    .body(body), .guard(guard), .sticky(sticky),
    .sat_hi(sat_hi), .sat_lo(sat_lo)
  );

  pe_round #(.N(N)) u_rnd (
    .cls(cls), .sign(in_sign), .body(body), .guard(guard), .sticky(sticky),
    .sat_hi(sat_hi), .sat_lo(sat_lo), .posit(out_posit)
  );
endmodule

// File: rtl/posit_encoder_chk.sv
module posit_encoder_chk #(
  parameter int N = 16
) (
  input logic         in_nar,
  input logic         in_sign,
  input logic         in_imp,
  input logic [N-1:0] out_posit,
  input logic         sat_hi,
  input logic         sat_lo
);
  localparam logic [N-1:0] NAR_C  = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MAXP_C = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] MINP_C = {{(N-1){1'b0}}, 1'b1};

  logic numeric;
  assign numeric = !in_nar && (in_sign || in_imp);

  always_comb begin
    if (in_nar)
      assert_nar_code_R1: assert (out_posit == NAR_C) else $error("R1 NaR code");
    if (!in_nar && !in_sign && !in_imp)
      assert_zero_code_R2: assert (out_posit == '0) else $error("R2 zero code");
    if (numeric)
      assert_no_zero_R8: assert (out_posit != '0) else $error("R8 flushed to zero");
    if (numeric)
      assert_no_nar_R7: assert (out_posit != NAR_C) else $error("R7 wrapped into NaR");
    if (numeric)
      assert_sign_kept_R9: assert (out_posit[N-1] == in_sign) else $error("R9 sign");
    if (numeric && sat_hi)
      assert_saturate_R7: assert (out_posit == (in_sign ? (~MAXP_C + 1'b1) : MAXP_C))
        else $error("R7 saturation");
    if (numeric && sat_lo)
      assert_minpos_R8: assert (out_posit == (in_sign ? {N{1'b1}} : MINP_C))
        else $error("R8 smallest magnitude");
  end
endmodule

bind posit_encoder posit_encoder_chk #(.N(N)) u_chk (
  .in_nar(in_nar), .in_sign(in_sign), .in_imp(in_imp),
  .out_posit(out_posit), .sat_hi(sat_hi), .sat_lo(sat_lo)
);

// File: tb/posit_encoder_tb.sv
module posit_encoder_tb;
  logic clk;
  logic rst_n;
  int   vectors;
  int   fails;
  int   cycles;
  bit   done;

  // N=8, ES=0: WE=4, WF=5
  logic       a_nar, a_sign, a_imp, a_rnd, a_stk;
  logic [3:0] a_exp;
  logic [4:0] a_frac;
  logic [7:0] a_out;
  // N=16, ES=1: WE=6, WF=12
  logic        b_nar, b_sign, b_imp, b_rnd, b_stk;
  logic [5:0]  b_exp;
  logic [11:0] b_frac;
  logic [15:0] b_out;

  posit_encoder #(.N(8), .ES(0)) u_dut8 (
    .in_nar(a_nar), .in_sign(a_sign), .in_exp(a_exp), .in_imp(a_imp),
    .in_frac(a_frac), .in_rnd(a_rnd), .in_stk(a_stk), .out_posit(a_out)
  );
  posit_encoder #(.N(16), .ES(1)) u_dut (
    .in_nar(b_nar), .in_sign(b_sign), .in_exp(b_exp), .in_imp(b_imp),
    .in_frac(b_frac), .in_rnd(b_rnd), .in_stk(b_stk), .out_posit(b_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // Arithmetic decode of posit p into intermediate-word fields.
  function automatic void dec(input int p, input int n, input int es,
                              output int nar, output int s, output int ex,
                              output int im, output int fr, output int fb);
    int wf, bias, m, rb, run, idx, k, rem, tail, full, esv, f, e;
    wf = n - 3 - es;
    bias = ((n - 2) << es) + 1;
    nar = 0; s = 0; ex = 0; im = 0; fr = 0; fb = 0;
    if (p == 0) return;
    if (p == (1 << (n - 1))) begin nar = 1; return; end
    s = (p >> (n - 1)) & 1;
    m = s ? ((1 << n) - p) : p;
    rb = (m >> (n - 2)) & 1;
    run = 0; idx = n - 2;
    while (idx >= 0 && (((m >> idx) & 1) == rb)) begin run++; idx--; end
    k = rb ? run - 1 : -run;
    idx--;
    rem = idx + 1;
    if (rem < 0) rem = 0;
    tail = m & ((1 << rem) - 1);
    full = tail << (es + wf - rem);
    esv = full >> wf;
    f = full & ((1 << wf) - 1);
    fb = rem - es;
    if (fb < 0) fb = 0;
    e = k * (1 << es) + esv;
    if (!s) begin im = 1; fr = f; ex = e + bias; end
    else if (f == 0) begin im = 0; fr = 0; ex = e - 1 + bias; end
    else begin im = 0; fr = (1 << wf) - f; ex = e + bias; end
  endfunction

  task automatic apply(input int n, input int nar, input int s, input int ex,
                       input int im, input int fr, input int r, input int st,
                       output int got);
    if (n == 8) begin
      a_nar = nar[0]; a_sign = s[0]; a_exp = ex[3:0]; a_imp = im[0];
      a_frac = fr[4:0]; a_rnd = r[0]; a_stk = st[0];
    end else begin
      b_nar = nar[0]; b_sign = s[0]; b_exp = ex[5:0]; b_imp = im[0];
      b_frac = fr[11:0]; b_rnd = r[0]; b_stk = st[0];
    end
    #2;
    got = (n == 8) ? int'(a_out) : int'(b_out);
    #1;
  endtask

  task automatic check(input string req, input int got, input int expv);
    vectors++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, expv);
    end
  endtask

  initial begin
    int got;
    vectors = 0; fails = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0;
    a_nar = 0; a_sign = 0; a_exp = '0; a_imp = 0; a_frac = '0; a_rnd = 0; a_stk = 0;
    b_nar = 0; b_sign = 0; b_exp = '0; b_imp = 0; b_frac = '0; b_rnd = 0; b_stk = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    check("R2 idle all-zero input (8)", int'(a_out), 0);
    check("R2 idle all-zero input (16)", int'(b_out), 0);

    // R3/R9/R1/R2: exhaustive re-encode of decoded posits
    for (int n = 8; n <= 16; n += 8) begin
      int es;
      es = (n == 8) ? 0 : 1;
      for (int p = 0; p < (1 << n); p++) begin
        int nar, s, ex, im, fr, fb;
        dec(p, n, es, nar, s, ex, im, fr, fb);
        apply(n, nar, s, ex, im, fr, 0, 0, got);
        if (p == 0) check("R2 zero", got, p);
        else if (nar) check("R1 NaR", got, p);
        else if (s) check("R9 negative round trip", got, p);
        else check("R3 positive round trip", got, p);
      end
    end

    // R4/R5: ties and near-ties between full-precision neighbours
    for (int n = 8; n <= 16; n += 8) begin
      int es, wf, msk;
      es = (n == 8) ? 0 : 1;
      wf = n - 3 - es;
      msk = (1 << n) - 1;
      for (int p = 0; p < (1 << n); p++) begin
        int nar, s, ex, im, fr, fb, nar2, s2, ex2, im2, fr2, fb2, q;
        q = (p + 1) & msk;
        dec(p, n, es, nar, s, ex, im, fr, fb);
        dec(q, n, es, nar2, s2, ex2, im2, fr2, fb2);
        if (p != 0 && q != 0 && !nar && !nar2 && fb == wf && fb2 == wf &&
            !(s == 1 && fr == 0)) begin
          apply(n, 0, s, ex, im, fr, 1, 0, got);
          check("R4 tie to even", got, ((p & 1) == 0) ? p : q);
          apply(n, 0, s, ex, im, fr, 1, 1, got);
          check("R5 above half", got, q);
          apply(n, 0, s, ex, im, fr, 0, 1, got);
          check("R5 below half", got, p);
        end
      end
    end

    // R6: rounding point inside the fraction at long regimes (N=8, bias 7)
    apply(8, 0, 0, 12, 1, 5'b10000, 0, 0, got); check("R6 tie at k=5", got, 8'h7E);
    apply(8, 0, 0, 12, 1, 5'b11000, 0, 0, got); check("R6 above half at k=5", got, 8'h7F);
    apply(8, 0, 0, 12, 1, 5'b01000, 0, 1, got); check("R6 below half at k=5", got, 8'h7E);
    apply(8, 0, 0, 11, 1, 5'b01000, 0, 0, got); check("R6 tie at k=4", got, 8'h7C);

    // R7: saturation and carries into the largest magnitude
    apply(8, 0, 0, 15, 1, 0, 0, 0, got);        check("R7 overflow pos (8)", got, 8'h7F);
    apply(8, 0, 1, 15, 0, 0, 0, 0, got);        check("R7 overflow neg (8)", got, 8'h81);
    apply(8, 0, 0, 13, 1, 5'b11111, 1, 1, got); check("R7 maxpos with tail", got, 8'h7F);
    apply(8, 0, 0, 12, 1, 5'b11111, 1, 1, got); check("R7 carry to maxpos", got, 8'h7F);
    apply(16, 0, 0, 63, 1, 0, 0, 0, got);       check("R7 overflow pos (16)", got, 16'h7FFF);
    apply(16, 0, 1, 63, 0, 12'h800, 1, 1, got); check("R7 overflow neg (16)", got, 16'h8001);

    // R8: underflow clamps to the smallest magnitude
    apply(8, 0, 0, 0, 1, 0, 0, 0, got);         check("R8 underflow pos (8)", got, 8'h01);
    apply(8, 0, 1, 0, 0, 5'b10000, 0, 0, got);  check("R8 underflow neg (8)", got, 8'hFF);
    apply(16, 0, 0, 0, 1, 12'hFFF, 1, 1, got);  check("R8 underflow pos (16)", got, 16'h0001);
    apply(16, 0, 1, 0, 0, 12'h001, 0, 1, got);  check("R8 underflow neg (16)", got, 16'hFFFF);

    // R1/R2: other fields ignored
    apply(8, 1, 1, 9, 1, 5'b10101, 1, 1, got);  check("R1 NaR with junk (8)", got, 8'h80);
    apply(16, 1, 0, 33, 1, 12'hABC, 1, 0, got); check("R1 NaR with junk (16)", got, 16'h8000);
    apply(8, 0, 0, 9, 0, 5'b10101, 1, 1, got);  check("R2 zero with junk (8)", got, 0);
    apply(16, 0, 0, 40, 0, 12'h5A5, 1, 1, got); check("R2 zero with junk (16)", got, 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule